// File: doc/BRIEF.md
# Dual-Mode Counter/Timer

This block is a 16-bit down-counter advanced by a clock-enable input, with two behaviours picked when it is started. As a timer it runs without end, producing a square wave whose half-period is the programmed preload in enabled ticks. The wave is meant to serve as a baud-rate clock. As a counter it runs one shot: it loads the preload, counts down, and marks the arrival at zero. It then keeps counting through the wrap until it is stopped.

Software writes the preload one byte at a time through two write strobes that share a byte-wide data bus. It controls the block with single-cycle start and stop strobes. It observes a ready flag and a wave output meant for a pin, and it can read the live count as two bytes. The preload cannot be read back. Values below 0x0002 are not legal preloads.

Top module: `ctmr_top`

## Requirements
- R1: After reset, `ready` is 0, `wave_out` is 1, the count reads 0x0000 and the preload is 0x0002.
- R2: A cycle with `wr_hi` high stores `wr_data` into preload bits 15:8. A cycle with `wr_lo` high stores it into bits 7:0. Writing one byte leaves the other unchanged.
- R3: Before the first `start_cmd`, enabled ticks and stop strobes leave the count at 0x0000 and `wave_out` high.
- R4: The count only moves on cycles with `tick_en` high. Cycles with `tick_en` low hold it.
- R5: Timer mode: after a start, `wave_out` is high for exactly preload enabled ticks, then low for preload ticks, and keeps alternating.
- R6: Timer mode: `ready` rises at the end of each low half-period, which is once per full wave cycle. `stop_cmd` clears `ready` but leaves the wave and the count running.
- R7: Timer mode: `start_cmd` abandons the current half-period, reloads the count from the preload and drives `wave_out` high.
- R8: Timer mode: a preload written in mid half-period does not shorten or lengthen that half-period. It sets the length of the next one.
- R9: Counter mode: `start_cmd` loads the preload. When the count reaches 0x0000, `ready` goes to 1 and `wave_out` goes low. The count then wraps to 0xFFFF and keeps decrementing.
- R10: Counter mode: `stop_cmd` halts the count, which stays readable, returns `wave_out` high and clears `ready`.
- R11: Counter mode: a preload written during a count is used only at the next start. A start with no new write reuses the previous preload.
- R12: `count_hi` and `count_lo` show bits 15:8 and 7:0 of the live count. The mode is taken from `mode_sel` (1 = timer, 0 = counter) on the start cycle, and later changes of `mode_sel` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count enable, one tick per high cycle |
| mode_sel | input | 1 | Mode taken at start: 1 timer, 0 counter |
| wr_data | input | 8 | Preload byte data |
| wr_hi | input | 1 | Write strobe for preload bits 15:8 |
| wr_lo | input | 1 | Write strobe for preload bits 7:0 |
| start_cmd | input | 1 | Start strobe |
| stop_cmd | input | 1 | Stop strobe |
| ready | output | 1 | Counter-ready flag |
| wave_out | output | 1 | Square wave (timer) or terminal-count level (counter) |
| count_hi | output | 8 | Live count bits 15:8 |
| count_lo | output | 8 | Live count bits 7:0 |

## Verification
Some rules are checked by the assertions on every cycle. The count holds while the block is idle. The timer count decrements by one on each tick. A start loads the preload and drives the wave high. A counter-mode terminal event drives the wave low and sets ready. A counter-mode low wave always comes with ready set. A stop that meets no terminal event clears ready. One preload byte stays put while the other is written.

Other behaviour only the bench scenarios can show. These include the exact half-period lengths and the once-per-cycle ready timing. They also include the preload change that lands in the next half-period, the restart mid-cycle, the wrap past zero with a stop, preload reuse across starts, the gapped tick pattern, and a mode input changed after start.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;
  typedef enum logic {
    MODE_COUNTER = 1'b0,
    MODE_TIMER   = 1'b1
  } ctmr_mode_e;
endpackage

// File: rtl/ctmr_preload.sv
module ctmr_preload #(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 2 * BYTE_W,
  parameter logic [CNT_W-1:0] PRELOAD_RST = CNT_W'(2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              wr_hi,
  input  logic              wr_lo,
  output logic [CNT_W-1:0]  preload_q
);
  localparam int LANES = CNT_W / BYTE_W;

  logic [LANES-1:0] lane_wr;
  assign lane_wr = {wr_hi, wr_lo};

  always_ff @(posedge clk) begin
    if (rst) begin
      preload_q <= PRELOAD_RST;
    end else begin
      for (int g = 0; g < LANES; g++) begin
        if (lane_wr[g]) preload_q[g*BYTE_W +: BYTE_W] <= wr_data;
      end
    end
  end

  // R2
  hi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_lo && !wr_hi) |=> $stable(preload_q[CNT_W-1 -: BYTE_W]));
endmodule

// File: rtl/ctmr_core.sv
module ctmr_core
  import ctmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             start_cmd,
  input  logic             stop_cmd,
  input  logic             mode_sel,
  input  logic [CNT_W-1:0] preload,
  output logic [CNT_W-1:0] cnt_q,
  output logic             running_q,
  output ctmr_mode_e       mode_q,
  output logic             zero_evt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic halt_req;
  logic at_one;

  assign halt_req = stop_cmd && (mode_q == MODE_COUNTER);
  assign at_one   = (cnt_q == ONE);
  assign zero_evt = running_q && tick_en && at_one && !start_cmd && !halt_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      running_q <= 1'b0;
      mode_q    <= MODE_COUNTER;
    end else if (start_cmd) begin
      cnt_q     <= preload;
      running_q <= 1'b1;
      mode_q    <= ctmr_mode_e'(mode_sel);
    end else if (halt_req) begin
      running_q <= 1'b0;
    end else if (running_q && tick_en) begin
      if (mode_q == MODE_TIMER && at_one) cnt_q <= preload;
      else                                cnt_q <= cnt_q - ONE;
    end
  end

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!running_q && !start_cmd) |=> $stable(cnt_q));

  // R4
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !start_cmd) |=> $stable(cnt_q));

  // R5
  timer_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (running_q && tick_en && !start_cmd && mode_q == MODE_TIMER && !at_one)
      |=> (cnt_q == $past(cnt_q) - ONE));

  // R7
  start_load_chk: assert property (@(posedge clk) disable iff (rst)
    start_cmd |=> (running_q && cnt_q == $past(preload)));
endmodule

// File: rtl/ctmr_outlogic.sv
module ctmr_outlogic
  import ctmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start_cmd,
  input  logic       stop_cmd,
  input  ctmr_mode_e mode_q,
  input  logic       zero_evt,
  output logic       wave_q,
  output logic       ready_q
);
  logic set_rdy;

  assign set_rdy = zero_evt && ((mode_q == MODE_COUNTER) || !wave_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      wave_q <= 1'b1;
    end else if (start_cmd) begin
      wave_q <= 1'b1;
    end else if (zero_evt) begin
      wave_q <= (mode_q == MODE_TIMER) ? !wave_q : 1'b0;
    end else if (stop_cmd && mode_q == MODE_COUNTER) begin
      wave_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           ready_q <= 1'b0;
    else if (set_rdy)  ready_q <= 1'b1;
    else if (stop_cmd) ready_q <= 1'b0;
  end

  // R7
  start_high_chk: assert property (@(posedge clk) disable iff (rst)
    start_cmd |=> wave_q);

  // R9
  term_evt_chk: assert property (@(posedge clk) disable iff (rst)
    (zero_evt && mode_q == MODE_COUNTER) |=> (!wave_q && ready_q));

  // R10
  low_has_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_COUNTER && !wave_q) |-> ready_q);

  // R6
  stop_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (stop_cmd && !zero_evt) |=> !ready_q);
endmodule

// File: rtl/ctmr_top.sv
module ctmr_top
  import ctmr_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              mode_sel,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic              start_cmd,
  input  logic              stop_cmd,
  output logic              ready,
  output logic              wave_out,
  output logic [BYTE_W-1:0] count_hi,
  output logic [BYTE_W-1:0] count_lo
);
  localparam int CNT_W = 2 * BYTE_W;

  logic [CNT_W-1:0] preload;
  logic [CNT_W-1:0] cnt_q;
  logic             running_q;
  ctmr_mode_e       mode_q;
  logic             zero_evt;

  ctmr_preload #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_pre (
    .clk(clk), .rst(rst), .wr_data(wr_data), .wr_hi(wr_hi), .wr_lo(wr_lo),
    .preload_q(preload)
  );

  ctmr_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .tick_en(tick_en), .start_cmd(start_cmd),
    .stop_cmd(stop_cmd), .mode_sel(mode_sel), .preload(preload),
    .cnt_q(cnt_q), .running_q(running_q), .mode_q(mode_q), .zero_evt(zero_evt)
  );

  ctmr_outlogic u_out (
    .clk(clk), .rst(rst), .start_cmd(start_cmd), .stop_cmd(stop_cmd),
    .mode_q(mode_q), .zero_evt(zero_evt), .wave_q(wave_out), .ready_q(ready)
  );

  assign count_hi = cnt_q[CNT_W-1 -: BYTE_W];
  assign count_lo = cnt_q[BYTE_W-1:0];

  // R12
  count_bytes_chk: assert property (@(posedge clk) disable iff (rst)
    !running_q |=> ($stable(count_hi) || $past(start_cmd)));
endmodule

// File: tb/test_ctmr_top.sv
module test_ctmr_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b0;
  logic       mode_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic       wr_hi = 1'b0;
  logic       wr_lo = 1'b0;
  logic       start_cmd = 1'b0;
  logic       stop_cmd = 1'b0;
  logic       ready;
  logic       wave_out;
  logic [7:0] count_hi;
  logic [7:0] count_lo;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ctmr_top i_ctmr_top (
    .clk(clk), .rst(rst), .tick_en(tick_en), .mode_sel(mode_sel),
    .wr_data(wr_data), .wr_hi(wr_hi), .wr_lo(wr_lo),
    .start_cmd(start_cmd), .stop_cmd(stop_cmd),
    .ready(ready), .wave_out(wave_out), .count_hi(count_hi), .count_lo(count_lo)
  );

  function automatic logic [15:0] count();
    return {count_hi, count_lo};
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    step();
    rst = 1'b1; tick_en = 1'b1; mode_sel = 1'b0; wr_hi = 1'b0; wr_lo = 1'b0;
    start_cmd = 1'b0; stop_cmd = 1'b0;
    repeat (3) step();
    rst = 1'b0;
    step();
  endtask

  task automatic set_pre(input logic [15:0] v);
    wr_hi = 1'b1; wr_data = v[15:8]; step();
    wr_hi = 1'b0; wr_lo = 1'b1; wr_data = v[7:0]; step();
    wr_lo = 1'b0;
  endtask

  task automatic start_mode(input logic m);
    start_cmd = 1'b1; mode_sel = m; step();
    start_cmd = 1'b0;
  endtask

  task automatic t_reset_idle();
    do_reset();
    chk("R1", "ready", ready, 0);
    chk("R1", "wave", wave_out, 1);
    chk("R1", "count", count(), 16'h0000);
    stop_cmd = 1'b1; step(); stop_cmd = 1'b0;
    repeat (4) step();
    chk("R3", "count idle", count(), 16'h0000);
    chk("R3", "wave idle", wave_out, 1);
    // R1 reset preload is 2
    start_mode(1'b0);
    chk("R1", "reset preload", count(), 16'h0002);
  endtask

  task automatic t_preload_bytes();
    do_reset();
    set_pre(16'h1234);
    start_mode(1'b0);
    chk("R12", "count_hi", count_hi, 8'h12);
    chk("R12", "count_lo", count_lo, 8'h34);
    stop_cmd = 1'b1; step(); stop_cmd = 1'b0;
    wr_hi = 1'b1; wr_data = 8'hAB; step(); wr_hi = 1'b0;
    start_mode(1'b0);
    chk("R2", "hi write only", count(), 16'hAB34);
  endtask

  task automatic t_timer_wave();
    localparam int P = 4;
    do_reset();
    set_pre(16'(P));
    start_mode(1'b1);
    mode_sel = 1'b0; // R12 mode changes after start are ignored
    for (int j = 1; j <= 4*P + 2; j++) begin
      chk("R5", $sformatf("wave j=%0d", j), wave_out, (((j-1)/P) % 2 == 0) ? 1 : 0);
      chk("R12", $sformatf("count j=%0d", j), count(), 16'(P - ((j-1) % P)));
      chk("R6", $sformatf("ready j=%0d", j), ready, (j == 2*P+1 || j >= 4*P+1) ? 1 : 0);
      stop_cmd = (j == 2*P+1);
      step();
    end
    stop_cmd = 1'b0;
  endtask

  task automatic t_timer_preload_change();
    do_reset();
    set_pre(16'd4);
    start_mode(1'b1);
    for (int j = 1; j <= 11; j++) begin
      if (j == 4)  chk("R8", "first half kept", wave_out, 1);
      if (j == 5)  chk("R8", "first half ends", wave_out, 0);
      if (j == 5)  chk("R8", "reload new", count(), 16'd6);
      if (j == 10) chk("R8", "second half long", wave_out, 0);
      if (j == 11) chk("R8", "second half ends", wave_out, 1);
      wr_lo = (j == 2); wr_data = 8'd6;
      step();
    end
    wr_lo = 1'b0;
  endtask

  task automatic t_timer_restart();
    do_reset();
    set_pre(16'd3);
    start_mode(1'b1);
    repeat (4) step();
    chk("R7", "low before restart", wave_out, 0);
    start_cmd = 1'b1; mode_sel = 1'b1; step(); start_cmd = 1'b0;
    chk("R7", "wave high", wave_out, 1);
    chk("R7", "count reload", count(), 16'd3);
    step(); step();
    chk("R7", "full half", wave_out, 1);
    step();
    chk("R7", "toggle", wave_out, 0);
  endtask

  task automatic t_counter_run();
    do_reset();
    set_pre(16'd5);
    start_mode(1'b0);
    for (int j = 1; j <= 9; j++) begin
      if (j == 5) begin
        chk("R9", "count 1", count(), 16'd1);
        chk("R9", "wave high", wave_out, 1);
        chk("R9", "ready low", ready, 0);
      end
      if (j == 6) begin
        chk("R9", "count 0", count(), 16'd0);
        chk("R9", "wave low", wave_out, 0);
        chk("R9", "ready set", ready, 1);
      end
      if (j == 7) chk("R9", "wrap", count(), 16'hFFFF);
      if (j == 9) chk("R9", "past zero", count(), 16'hFFFD);
      wr_lo = (j == 8); wr_data = 8'd9;
      stop_cmd = (j == 9);
      step();
    end
    wr_lo = 1'b0; stop_cmd = 1'b0;
    chk("R10", "count held", count(), 16'hFFFD);
    chk("R10", "wave high", wave_out, 1);
    chk("R10", "ready clear", ready, 0);
    step(); step();
    chk("R10", "still held", count(), 16'hFFFD);
    start_mode(1'b0);
    chk("R11", "new preload", count(), 16'd9);
    stop_cmd = 1'b1; step(); stop_cmd = 1'b0;
    start_mode(1'b0);
    chk("R11", "reused preload", count(), 16'd9);
    step();
    chk("R11", "counting", count(), 16'd8);
  endtask

  task automatic t_gapped_ticks();
    do_reset();
    set_pre(16'd3);
    start_mode(1'b0);
    for (int j = 1; j <= 6; j++) begin
      if (j == 3) chk("R4", "held no tick", count(), 16'd2);
      if (j == 5) chk("R4", "count 1", count(), 16'd1);
      if (j == 5) chk("R4", "ready low", ready, 0);
      if (j == 6) chk("R4", "count 0", count(), 16'd0);
      if (j == 6) chk("R4", "ready set", ready, 1);
      tick_en = (j % 2 == 1);
      step();
    end
    tick_en = 1'b1;
  endtask

  initial begin
    t_reset_idle();
    t_preload_bytes();
    t_timer_wave();
    t_timer_preload_change();
    t_timer_restart();
    t_counter_run();
    t_gapped_ticks();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule